// File: doc/BRIEF.md
# Sensor Command Decoder and Zone Register File

This block sits behind the byte receiver of a line-sensor control interface. Each accepted byte is read as either a one-byte action command or the first byte of a two-byte register write. Action commands become single-cycle strobes for a separate imaging sequencer. Register writes land in a small register file. That file holds a gain and an offset for each of three pixel zones, plus a mode byte whose sleep bit is exported.

A register-read command sends the addressed value back on a serial line. The frame is a low start bit, eight data bits least significant first, and a high stop bit. It starts after a fixed gap of four clocks, and the line changes only on falling clock edges. A break event puts the decoder back into the state where it expects a command byte. A run of reset opcodes does the same, because any stray byte is used up as write data.

Top module: `sensor_cmd_decoder`

## Requirements
- R1: A byte accepted at a rising edge (rxValid high, breakEvt low) gives a strobe that is high for exactly the following clock cycle. The decoder must be expecting a command byte. The codes are: 0x1B pulses actReset, 0x08 pulses actStart, 0x10 pulses actSample, 0x02 pulses actRead, 0x19 pulses actAbort.
- R2: Opcode 0x12 pulses actSample and actRead in the same cycle. Opcode 0x16 pulses actSample, actRead and actStart in the same cycle.
- R3: A command byte 010aaaaa makes the next accepted byte the data for address aaaaa. That data byte never raises an action strobe, even when its value equals an action opcode.
- R4: Zone z (0 left, 1 center, 2 right) has its 8-bit offset at address 2z and its gain at address 2z+1. zoneOffset[8z+7:8z] and zoneGain[5z+4:5z] show the stored values. Offsets are kept raw as sign-magnitude (bit 7 = negative).
- R5: A gain write keeps only bits 4:0 of the data byte. A gain reads back with bits 7:5 zero.
- R6: Address 0x1F holds the 8-bit mode register, shown on modeReg. sleep equals mode bit 4. Action commands still pulse their strobes while sleep is set.
- R7: A command byte 011aaaaa accepted at rising edge k sends a 10-bit frame: a start bit 0, data bits 0 to 7, then a stop bit 1. txOut stays high for the falling edges after edges k+1 to k+3. The start bit appears at the falling edge after rising edge k+4, and each later bit one clock after the one before. txOut is high when idle.
- R8: Reads of addresses other than 0 to 5 and 0x1F return 0x00. Writes to them change no register.
- R9: An unrecognized byte received while a command is expected (for example 0x00, 0xFF, 0x9B) raises no strobe and changes no register. The next byte is again decoded as a command.
- R10: breakEvt returns the decoder to expecting a command and discards a pending write. A byte presented in the same cycle as breakEvt is dropped.
- R11: Three successive 0x1B bytes resynchronize the decoder. If a write was pending, the first 0x1B is written as data and the next two each pulse actReset.
- R12: After reset all registers are zero, all strobes and sleep are low, and txOut is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock; all state on its rising edge, txOut on its falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rxByte | input | 8 | Received byte |
| rxValid | input | 1 | rxByte is valid this cycle |
| breakEvt | input | 1 | Interface break detected |
| actReset | output | 1 | Pixel/readout reset strobe |
| actStart | output | 1 | Start-integration strobe |
| actSample | output | 1 | Sample-integrators strobe |
| actRead | output | 1 | Pixel readout strobe |
| actAbort | output | 1 | Abort readout strobe |
| zoneOffset | output | 24 | Per-zone offsets, zone 0 in the low byte |
| zoneGain | output | 15 | Per-zone 5-bit gains, zone 0 in the low bits |
| modeReg | output | 8 | Mode register |
| sleep | output | 1 | Sleep flag (mode bit 4) |
| txOut | output | 1 | Serial readback line |

## Verification
The decoder is tried with each action opcode on its own and with the compound opcodes. This separates single-strobe from multi-strobe decoding. Writes whose data bytes look like opcodes show whether the data phase is kept apart from command decoding. Unrecognized bytes, break pulses (with and without a byte in the same cycle) and reset runs after a dangling write command each test a different path back to the command state. Readbacks of gains, offsets, mode and unimplemented addresses check the frame bit by bit at the falling edges. This confirms the four-clock gap, the bit order and the gain masking.

// File: rtl/sensor_cmd_pkg.sv
package sensor_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 5;

  localparam logic [7:0] OP_RESET     = 8'h1B;
  localparam logic [7:0] OP_START     = 8'h08;
  localparam logic [7:0] OP_SAMPLE    = 8'h10;
  localparam logic [7:0] OP_READ      = 8'h02;
  localparam logic [7:0] OP_ABORT     = 8'h19;
  localparam logic [7:0] OP_HOLD      = 8'h12;
  localparam logic [7:0] OP_HOLDSTART = 8'h16;
  localparam logic [2:0] GRP_WRITE    = 3'b010;
  localparam logic [2:0] GRP_READ     = 3'b011;

  typedef enum logic {S_CMD, S_DATA} decState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              wrEn;
    logic              rdEn;
    logic [ADDR_W-1:0] addr;
  } regCmd_t;

  typedef struct packed {
    logic rst;
    logic start;
    logic sample;
    logic read;
    logic abort;
  } action_t;
endpackage

// File: rtl/sensor_cmd_ctrl.sv
module sensor_cmd_ctrl
  import sensor_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [BYTE_W-1:0] rxByte,
  input  logic              rxValid,
  input  logic              breakEvt,
  output regCmd_t           regCmd,
  output action_t           actQ
);
  decState_t         state;
  logic [ADDR_W-1:0] pendAddr;
  logic              accept;
  logic              inCmd;
  action_t           actNext;

  assign accept = rxValid && !breakEvt;
  assign inCmd  = accept && (state == S_CMD);

  always_comb begin
    actNext = '0;
    if (inCmd) begin
      unique case (rxByte)
        OP_RESET:     actNext.rst = 1'b1;
        OP_START:     actNext.start = 1'b1;
        OP_SAMPLE:    actNext.sample = 1'b1;
        OP_READ:      actNext.read = 1'b1;
        OP_ABORT:     actNext.abort = 1'b1;
        OP_HOLD:      begin actNext.sample = 1'b1; actNext.read = 1'b1; end
        OP_HOLDSTART: begin actNext.sample = 1'b1; actNext.read = 1'b1; actNext.start = 1'b1; end
        default:      actNext = '0;
      endcase
    end
  end

  always_comb begin
    regCmd.wrEn = accept && (state == S_DATA);
    regCmd.rdEn = inCmd && (rxByte[7:5] == GRP_READ);
    regCmd.addr = (state == S_DATA) ? pendAddr : rxByte[ADDR_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_CMD;
      pendAddr <= '0;
      actQ     <= '0;
    end else begin
      actQ <= actNext;
      if (breakEvt) begin
        state <= S_CMD;
      end else if (inCmd && rxByte[7:5] == GRP_WRITE) begin
        state    <= S_DATA;
        pendAddr <= rxByte[ADDR_W-1:0];
      end else if (accept) begin
        state <= S_CMD;
      end
    end
  end

  assert_break_resync_R10: assert property (@(posedge clk) disable iff (!rstN)
    breakEvt |=> state == S_CMD);
  assert_strobe_source_R1: assert property (@(posedge clk) disable iff (!rstN)
    (|actQ) |-> ($past(rxValid) && !$past(breakEvt)));
  assert_data_no_action_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DATA && rxValid) |=> !(|actQ));
endmodule

// File: rtl/sensor_cmd_datapath.sv
module sensor_cmd_datapath
  import sensor_cmd_pkg::*;
#(
  parameter int NUM_ZONES = 3,
  parameter int GAIN_W    = 5,
  parameter int READ_GAP  = 4,
  parameter int MODE_ADDR = 31,
  parameter int SLEEP_BIT = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  regCmd_t                     regCmd,
  input  logic [BYTE_W-1:0]           wrData,
  output logic [NUM_ZONES*BYTE_W-1:0] zoneOffset,
  output logic [NUM_ZONES*GAIN_W-1:0] zoneGain,
  output logic [BYTE_W-1:0]           modeReg,
  output logic                        sleep,
  output logic                        txOut
);
  localparam int FRAME_W = BYTE_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int GAP_W   = $clog2(READ_GAP + 1);

  logic [BYTE_W-1:0]  offsetQ [NUM_ZONES];
  logic [GAIN_W-1:0]  gainQ   [NUM_ZONES];
  logic [BYTE_W-1:0]  modeQ;
  logic [BYTE_W-1:0]  rdData;
  logic [FRAME_W-1:0] shiftQ;
  logic [CNT_W-1:0]   bitCnt;
  logic [GAP_W-1:0]   gapCnt;
  logic               txLine;

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offsetQ[z] <= '0;
        gainQ[z]   <= '0;
      end else if (regCmd.wrEn) begin
        if (regCmd.addr == ADDR_W'(2*z))   offsetQ[z] <= wrData;
        if (regCmd.addr == ADDR_W'(2*z+1)) gainQ[z]   <= wrData[GAIN_W-1:0];
      end
    end
    assign zoneOffset[z*BYTE_W +: BYTE_W] = offsetQ[z];
    assign zoneGain[z*GAIN_W +: GAIN_W]   = gainQ[z];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            modeQ <= '0;
    else if (regCmd.wrEn && regCmd.addr == ADDR_W'(MODE_ADDR)) modeQ <= wrData;
  end
  assign modeReg = modeQ;
  assign sleep   = modeQ[SLEEP_BIT];

  always_comb begin
    rdData = '0;
    if (regCmd.addr == ADDR_W'(MODE_ADDR)) rdData = modeQ;
    for (int z = 0; z < NUM_ZONES; z++) begin
      if (regCmd.addr == ADDR_W'(2*z))   rdData = offsetQ[z];
      if (regCmd.addr == ADDR_W'(2*z+1)) rdData = BYTE_W'(gainQ[z]);
    end
  end

  // frame sequencing on the rising edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ <= '1;
      bitCnt <= '0;
      gapCnt <= '0;
      txLine <= 1'b1;
    end else if (regCmd.rdEn) begin
      shiftQ <= {1'b1, rdData, 1'b0};
      bitCnt <= CNT_W'(FRAME_W);
      gapCnt <= GAP_W'(READ_GAP - 1);
      txLine <= 1'b1;
    end else if (gapCnt != '0) begin
      gapCnt <= gapCnt - 1'b1;
    end else if (bitCnt != '0) begin
      txLine <= shiftQ[0];
      shiftQ <= {1'b1, shiftQ[FRAME_W-1:1]};
      bitCnt <= bitCnt - 1'b1;
    end else begin
      txLine <= 1'b1;
    end
  end

  // retime to the falling edge
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) txOut <= 1'b1;
    else       txOut <= txLine;
  end

  assert_gap_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    regCmd.rdEn |=> txLine);
  assert_gain_mask_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regCmd.wrEn && regCmd.addr == ADDR_W'(1)) |=> gainQ[0] == $past(wrData[GAIN_W-1:0]));
  assert_mode_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regCmd.wrEn && regCmd.addr == ADDR_W'(MODE_ADDR)) |=> modeQ == $past(wrData));
  assert_offset_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regCmd.wrEn && regCmd.addr == ADDR_W'(0)) |=> offsetQ[0] == $past(wrData));
endmodule

// File: rtl/sensor_cmd_decoder.sv
module sensor_cmd_decoder
  import sensor_cmd_pkg::*;
#(
  parameter int NUM_ZONES = 3,
  parameter int GAIN_W    = 5,
  parameter int READ_GAP  = 4,
  parameter int MODE_ADDR = 31,
  parameter int SLEEP_BIT = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [7:0]                  rxByte,
  input  logic                        rxValid,
  input  logic                        breakEvt,
  output logic                        actReset,
  output logic                        actStart,
  output logic                        actSample,
  output logic                        actRead,
  output logic                        actAbort,
  output logic [NUM_ZONES*8-1:0]      zoneOffset,
  output logic [NUM_ZONES*GAIN_W-1:0] zoneGain,
  output logic [7:0]                  modeReg,
  output logic                        sleep,
  output logic                        txOut
);
  regCmd_t regCmd;
  action_t actQ;

  sensor_cmd_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid),
    .breakEvt(breakEvt), .regCmd(regCmd), .actQ(actQ)
  );

  sensor_cmd_datapath #(
    .NUM_ZONES(NUM_ZONES), .GAIN_W(GAIN_W), .READ_GAP(READ_GAP),
    .MODE_ADDR(MODE_ADDR), .SLEEP_BIT(SLEEP_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .regCmd(regCmd), .wrData(rxByte),
    .zoneOffset(zoneOffset), .zoneGain(zoneGain), .modeReg(modeReg),
    .sleep(sleep), .txOut(txOut)
  );

  assign actReset  = actQ.rst;
  assign actStart  = actQ.start;
  assign actSample = actQ.sample;
  assign actRead   = actQ.read;
  assign actAbort  = actQ.abort;
endmodule

// File: tb/sensor_cmd_decoder_tb.sv
module sensor_cmd_decoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  rxByte = 8'h00;
  logic        rxValid = 1'b0;
  logic        breakEvt = 1'b0;
  logic        actReset, actStart, actSample, actRead, actAbort;
  logic [23:0] zoneOffset;
  logic [14:0] zoneGain;
  logic [7:0]  modeReg;
  logic        sleep, txOut;
  int          nChecks = 0;
  int          nFails = 0;

  always #5 clk = ~clk;

  sensor_cmd_decoder u_dut (
    .clk(clk), .rstN(rstN), .rxByte(rxByte), .rxValid(rxValid), .breakEvt(breakEvt),
    .actReset(actReset), .actStart(actStart), .actSample(actSample), .actRead(actRead),
    .actAbort(actAbort), .zoneOffset(zoneOffset), .zoneGain(zoneGain),
    .modeReg(modeReg), .sleep(sleep), .txOut(txOut)
  );

  // {reset, start, sample, read, abort}
  function automatic logic [4:0] strobes();
    return {actReset, actStart, actSample, actRead, actAbort};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // returns at the falling edge after the accepting rising edge
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxByte = b; rxValid = 1'b1;
    @(negedge clk); rxValid = 1'b0;
    #1;
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [7:0] d);
    sendByte({3'b010, a});
    sendByte(d);
  endtask

  task automatic checkAction(input logic [7:0] op, input logic [4:0] exp, input string req);
    sendByte(op);
    chk(strobes() == exp, req, strobes(), exp);
    @(negedge clk); #1;
    chk(strobes() == 5'b0, {req, " pulse width"}, strobes(), 0);
  endtask

  task automatic checkRead(input logic [4:0] a, input logic [7:0] exp, input string req);
    logic [9:0] got;
    logic [2:0] gap;
    sendByte({3'b011, a});
    for (int i = 0; i < 3; i++) begin @(negedge clk); #1; gap[i] = txOut; end
    for (int i = 0; i < 10; i++) begin @(negedge clk); #1; got[i] = txOut; end
    chk(gap == 3'b111, {req, " gap"}, gap, 3'b111);
    chk(got == {1'b1, exp, 1'b0}, {req, " frame"}, got, {1'b1, exp, 1'b0});
    @(negedge clk); #1;
    chk(txOut == 1'b1, {req, " idle"}, txOut, 1);
  endtask

  task automatic testReset();
    chk(zoneOffset == 0 && zoneGain == 0 && modeReg == 0, "R12 regs", {zoneGain, modeReg}, 0);
    chk(strobes() == 0 && !sleep && txOut, "R12 outputs", {strobes(), sleep, txOut}, 1);
  endtask

  task automatic testActions();
    checkAction(8'h1B, 5'b10000, "R1 reset");
    checkAction(8'h08, 5'b01000, "R1 start");
    checkAction(8'h10, 5'b00100, "R1 sample");
    checkAction(8'h02, 5'b00010, "R1 read");
    checkAction(8'h19, 5'b00001, "R1 abort");
    checkAction(8'h12, 5'b00110, "R2 hold");
    checkAction(8'h16, 5'b01110, "R2 hold-start");
  endtask

  task automatic testWrites();
    writeReg(5'd0, 8'hA5); writeReg(5'd1, 8'hFF); writeReg(5'd2, 8'h83);
    writeReg(5'd3, 8'h0C); writeReg(5'd4, 8'h7F); writeReg(5'd5, 8'h35);
    chk(zoneOffset == 24'h7F83A5, "R4 offsets", zoneOffset, 24'h7F83A5);
    chk(zoneGain == {5'h15, 5'h0C, 5'h1F}, "R5 gains", zoneGain, {5'h15, 5'h0C, 5'h1F});
    checkRead(5'd1, 8'h1F, "R5 gain readback");
    checkRead(5'd4, 8'h7F, "R7 offset readback");
    checkRead(5'd0, 8'hA5, "R7 pattern readback");
    checkRead(5'd2, 8'h83, "R4 negative offset readback");
    // data byte equal to an opcode
    sendByte(8'h42);
    sendByte(8'h08);
    chk(strobes() == 0, "R3 data not decoded", strobes(), 0);
    chk(zoneOffset[15:8] == 8'h08, "R3 data written", zoneOffset[15:8], 8'h08);
  endtask

  task automatic testUnimpl();
    writeReg(5'd6, 8'h55);
    writeReg(5'd16, 8'h66);
    chk(zoneOffset == 24'h7F08A5 && zoneGain == {5'h15, 5'h0C, 5'h1F} && modeReg == 0,
        "R8 writes ignored", zoneOffset, 24'h7F08A5);
    checkRead(5'd6, 8'h00, "R8 read addr 6");
    checkRead(5'd16, 8'h00, "R8 read addr 16");
  endtask

  task automatic testMode();
    writeReg(5'd31, 8'h10);
    chk(sleep && modeReg == 8'h10, "R6 sleep set", modeReg, 8'h10);
    checkRead(5'd31, 8'h10, "R6 mode readback");
    checkAction(8'h19, 5'b00001, "R6 command while asleep");
    writeReg(5'd31, 8'h00);
    chk(!sleep, "R6 sleep clear", sleep, 0);
  endtask

  task automatic testUnknown();
    checkAction(8'h00, 5'b0, "R9 byte 00");
    checkAction(8'hFF, 5'b0, "R9 byte FF");
    checkAction(8'h9B, 5'b0, "R9 byte 9B");
    checkAction(8'h02, 5'b00010, "R9 next decoded");
    chk(zoneOffset == 24'h7F08A5 && modeReg == 0, "R9 regs unchanged", zoneOffset, 24'h7F08A5);
  endtask

  task automatic testBreak();
    sendByte(8'h40);
    @(negedge clk); breakEvt = 1'b1;
    @(negedge clk); breakEvt = 1'b0; #1;
    checkAction(8'h10, 5'b00100, "R10 command after break");
    chk(zoneOffset[7:0] == 8'hA5, "R10 pending write dropped", zoneOffset[7:0], 8'hA5);
    @(negedge clk); breakEvt = 1'b1; rxByte = 8'h08; rxValid = 1'b1;
    @(negedge clk); breakEvt = 1'b0; rxValid = 1'b0; #1;
    chk(strobes() == 0, "R10 byte with break dropped", strobes(), 0);
  endtask

  task automatic testResync();
    sendByte(8'h44);
    sendByte(8'h1B);
    chk(strobes() == 0, "R11 first 1B as data", strobes(), 0);
    chk(zoneOffset[23:16] == 8'h1B, "R11 data stored", zoneOffset[23:16], 8'h1B);
    checkAction(8'h1B, 5'b10000, "R11 second 1B");
    checkAction(8'h1B, 5'b10000, "R11 third 1B");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    testReset();
    rstN = 1'b1;
    testActions();
    testWrites();
    testUnimpl();
    testMode();
    testUnknown();
    testBreak();
    testResync();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    #1_000_000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule